// File: doc/BRIEF.md
# E1 Sa-Bit Serial Maintenance Link

This block carries a 4 kbit/s serial maintenance channel in one national bit of the E1 time-slot-zero non-frame-alignment frames. Software picks the carrier bit (Sa4 to Sa8) with a one-hot select word. The block builds a 4 kHz data link clock from the system frame timing and exports it to an external HDLC controller. It shifts received data out in step with that clock, and it hands one transmit bit per two frames to the time-slot-zero formatter, together with an override enable and a position mask.

The exported clock toggles on every system frame pulse. It is high for one frame and low for the next, so one period covers an FAS/NFAS pair. The internal transmit sample clock is the inverse of the exported clock. Transmit data is therefore captured on each falling edge of the exported clock, which is the rising edge of the internal clock. Received NFAS bytes arrive on their own strobe, which may drift against system timing when the receiver slips. The latest extracted bit is moved to the receive output only on the exported clock's falling edge. A slip can then drop or repeat a receive bit, but it never moves the clock phase.

Top module: `sa_data_link`

## Requirements
- R1: After reset, dlclk_o is 0, rxdl_o is 1, tx_bit_o is 1, tx_ovr_o is 0 and tx_sa_mask_o is 0.
- R2: dlclk_o inverts on the clock edge that samples frame_i high, and holds its value on every other edge.
- R3: With exactly one bit of sel_i set (sel_i[0] = Sa4 ... sel_i[4] = Sa8), tx_ovr_o is 1 and tx_sa_mask_o equals sel_i.
- R4: With sel_i zero or with more than one bit set, tx_ovr_o is 0, tx_sa_mask_o is 0 and rxdl_o is forced to 1.
- R5: txdl_i is captured on the edge where frame_i is high while dlclk_o is 1 (the falling edge of the exported clock, which is the rising edge of the internal clock). tx_bit_o presents that value from the next cycle. txdl_i has no effect at any other edge, including frame pulses while dlclk_o is 0.
- R6: The received bit is taken from rx_nfas_i on each rx_nfas_vld_i strobe. rx_nfas_i[7] is channel bit 1 (MSB), so Sa4 is rx_nfas_i[4], Sa5 is [3], Sa6 is [2], Sa7 is [1] and Sa8 is [0].
- R7: rxdl_o changes only on a falling edge of dlclk_o, and it then shows the bit of the latest strobe received before that edge.
- R8: Under a slip, two strobes within one clock period lose the earlier bit, and a period with no strobe repeats the previous bit. Receive strobes never change the dlclk_o phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | One-cycle pulse at each system frame boundary |
| sel_i | input | 5 | One-hot carrier select, bit 0 = Sa4 to bit 4 = Sa8 |
| rx_nfas_i | input | 8 | Received NFAS byte, bit 7 = channel bit 1 |
| rx_nfas_vld_i | input | 1 | Strobe marking a new rx_nfas_i byte |
| txdl_i | input | 1 | Serial transmit data from the HDLC controller |
| dlclk_o | output | 1 | Exported 4 kHz data link clock |
| rxdl_o | output | 1 | Serial receive data aligned to dlclk_o |
| tx_bit_o | output | 1 | Transmit bit for the formatter |
| tx_ovr_o | output | 1 | Override enable for the selected national bit |
| tx_sa_mask_o | output | 5 | One-hot position to override, zero when disabled |

## Verification
Each select position is driven with a byte that has only the target bit set and then with its complement. A wrong bit mapping shows up as a mismatch in one of the two. Select words with no bit set and with two bits set separate a true one-hot check from a plain OR of the bits. Transmit data changed on the rising-edge frame pulse and between pulses separates capture on the falling edge from capture on any pulse. Double strobes and missing strobes inside one clock period show that a loss or repeat happens while dlclk_o keeps its phase.

// File: rtl/sa_dl_pkg.sv
package sa_dl_pkg;
  localparam int unsigned SA_COUNT = 5;
  localparam int unsigned TS_BITS  = 8;

  typedef struct packed {
    logic rise;
    logic fall;
  } dl_evt_t;
endpackage

// File: rtl/dl_clk_gen.sv
module dl_clk_gen
  import sa_dl_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    frame_i,
  output logic    dlclk_o,
  output dl_evt_t evt_o
);
  logic dlclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dlclk_q <= 1'b0;
    else if (frame_i) dlclk_q <= ~dlclk_q;
  end

  assign dlclk_o    = dlclk_q;
  assign evt_o.rise = frame_i & ~dlclk_q;
  assign evt_o.fall = frame_i &  dlclk_q;

  // R2
  dlclk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> (dlclk_o != $past(dlclk_o)));
  // R2
  dlclk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(dlclk_o));
endmodule

// File: rtl/dl_sel_decode.sv
module dl_sel_decode #(
  parameter int unsigned NUM_SA = sa_dl_pkg::SA_COUNT
) (
  input  logic [NUM_SA-1:0] sel_i,
  output logic              en_o,
  output logic [NUM_SA-1:0] mask_o
);
  localparam int unsigned CNT_W = $clog2(NUM_SA + 1);

  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < NUM_SA; i++) ones = ones + CNT_W'(sel_i[i]);
  end

  assign en_o   = (ones == CNT_W'(1));
  assign mask_o = en_o ? sel_i : '0;
endmodule

// File: rtl/dl_rx_path.sv
module dl_rx_path #(
  parameter int unsigned NUM_SA = sa_dl_pkg::SA_COUNT,
  parameter int unsigned BYTE_W = sa_dl_pkg::TS_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [NUM_SA-1:0] mask_i,
  input  logic [BYTE_W-1:0] nfas_i,
  input  logic              nfas_vld_i,
  input  logic              fall_i,
  output logic              rxdl_o
);
  logic [NUM_SA-1:0] sa_vec;
  logic              pick;
  logic              hold_q;
  logic              rxdl_q;

  // Sa4 sits nearest the MSB: select bit k maps to byte bit NUM_SA-1-k
  for (genvar k = 0; k < NUM_SA; k++) begin : g_map
    assign sa_vec[k] = nfas_i[NUM_SA-1-k];
  end

  assign pick = |(sa_vec & mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b1;
      rxdl_q <= 1'b1;
    end else begin
      if (nfas_vld_i && en_i) hold_q <= pick;
      if (fall_i)             rxdl_q <= hold_q;
    end
  end

  assign rxdl_o = en_i ? rxdl_q : 1'b1;

  // R7
  rx_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(rxdl_q));
endmodule

// File: rtl/dl_tx_path.sv
module dl_tx_path (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic txdl_i,
  output logic tx_bit_o
);
  logic tx_q;

  // cap_i is the internal (inverted) clock rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tx_q <= 1'b1;
    else if (cap_i) tx_q <= txdl_i;
  end

  assign tx_bit_o = tx_q;

  // R5
  tx_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (tx_bit_o == $past(txdl_i)));
  // R5
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(tx_bit_o));
endmodule

// File: rtl/sa_data_link.sv
module sa_data_link
  import sa_dl_pkg::*;
#(
  parameter int unsigned NUM_SA = SA_COUNT,
  parameter int unsigned BYTE_W = TS_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [NUM_SA-1:0] sel_i,
  input  logic [BYTE_W-1:0] rx_nfas_i,
  input  logic              rx_nfas_vld_i,
  input  logic              txdl_i,
  output logic              dlclk_o,
  output logic              rxdl_o,
  output logic              tx_bit_o,
  output logic              tx_ovr_o,
  output logic [NUM_SA-1:0] tx_sa_mask_o
);
  dl_evt_t           evt;
  logic              en;
  logic [NUM_SA-1:0] mask;

  dl_clk_gen i_clk_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .frame_i(frame_i),
    .dlclk_o(dlclk_o),
    .evt_o  (evt)
  );

  dl_sel_decode #(.NUM_SA(NUM_SA)) i_sel_decode (
    .sel_i (sel_i),
    .en_o  (en),
    .mask_o(mask)
  );

  dl_rx_path #(.NUM_SA(NUM_SA), .BYTE_W(BYTE_W)) i_rx_path (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .mask_i    (mask),
    .nfas_i    (rx_nfas_i),
    .nfas_vld_i(rx_nfas_vld_i),
    .fall_i    (evt.fall),
    .rxdl_o    (rxdl_o)
  );

  dl_tx_path i_tx_path (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (evt.fall),
    .txdl_i  (txdl_i),
    .tx_bit_o(tx_bit_o)
  );

  assign tx_ovr_o     = en;
  assign tx_sa_mask_o = mask;

  // R3
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(sel_i) == 1) |-> (tx_ovr_o && tx_sa_mask_o == sel_i));
  // R4
  sel_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(sel_i) != 1) |-> (!tx_ovr_o && tx_sa_mask_o == '0 && rxdl_o));
  // R3
  mask_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tx_sa_mask_o));
endmodule

// File: tb/test_sa_data_link.sv
module test_sa_data_link;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_i = 1'b0;
  logic [4:0] sel_i = 5'b00001;
  logic [7:0] rx_nfas_i = 8'h00;
  logic       rx_nfas_vld_i = 1'b0;
  logic       txdl_i = 1'b1;
  logic       dlclk_o, rxdl_o, tx_bit_o, tx_ovr_o;
  logic [4:0] tx_sa_mask_o;

  int  n_run = 0;
  int  n_fail = 0;
  bit  exp_clk = 1'b0;
  bit  done = 1'b0;

  always #5 clk_i = ~clk_i;

  sa_data_link i_sa_data_link (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .sel_i(sel_i),
    .rx_nfas_i(rx_nfas_i), .rx_nfas_vld_i(rx_nfas_vld_i), .txdl_i(txdl_i),
    .dlclk_o(dlclk_o), .rxdl_o(rxdl_o), .tx_bit_o(tx_bit_o),
    .tx_ovr_o(tx_ovr_o), .tx_sa_mask_o(tx_sa_mask_o)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic pulse();
    @(negedge clk_i) frame_i = 1'b1;
    @(negedge clk_i) frame_i = 1'b0;
    exp_clk = ~exp_clk;
    chk({7'd0, dlclk_o}, {7'd0, exp_clk}, "R2 dlclk phase");
    idle(3);
  endtask

  task automatic to_fall();
    if (!exp_clk) pulse();
    pulse();
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk_i) begin rx_nfas_i = b; rx_nfas_vld_i = 1'b1; end
    @(negedge clk_i) rx_nfas_vld_i = 1'b0;
  endtask

  task automatic t_reset();
    idle(2);
    chk({7'd0, dlclk_o}, 8'd0, "R1 dlclk");
    chk({7'd0, rxdl_o}, 8'd1, "R1 rxdl");
    chk({7'd0, tx_bit_o}, 8'd1, "R1 tx_bit");
    rst_ni = 1'b1;
    sel_i = 5'b00000;
    idle(1);
    chk({7'd0, tx_ovr_o}, 8'd0, "R1 ovr");
    chk({3'd0, tx_sa_mask_o}, 8'd0, "R1 mask");
  endtask

  task automatic t_clock();
    for (int i = 0; i < 4; i++) pulse();
    idle(5);
    chk({7'd0, dlclk_o}, {7'd0, exp_clk}, "R2 hold between pulses");
  endtask

  task automatic t_select();
    for (int k = 0; k < 5; k++) begin
      sel_i = 5'(1 << k);
      idle(1);
      chk({7'd0, tx_ovr_o}, 8'd1, "R3 ovr");
      chk({3'd0, tx_sa_mask_o}, {3'd0, sel_i}, "R3 mask");
    end
  endtask

  task automatic t_invalid();
    sel_i = 5'b00001;
    send(8'h00);
    to_fall();
    chk({7'd0, rxdl_o}, 8'd0, "R4 setup rxdl");
    sel_i = 5'b00000;
    idle(1);
    chk({7'd0, tx_ovr_o}, 8'd0, "R4 zero ovr");
    chk({3'd0, tx_sa_mask_o}, 8'd0, "R4 zero mask");
    chk({7'd0, rxdl_o}, 8'd1, "R4 zero rxdl");
    sel_i = 5'b10010;
    idle(1);
    chk({7'd0, tx_ovr_o}, 8'd0, "R4 multi ovr");
    chk({3'd0, tx_sa_mask_o}, 8'd0, "R4 multi mask");
    chk({7'd0, rxdl_o}, 8'd1, "R4 multi rxdl");
    sel_i = 5'b00001;
    idle(1);
  endtask

  task automatic t_tx();
    if (exp_clk) pulse();
    txdl_i = 1'b0;
    pulse();
    chk({7'd0, tx_bit_o}, 8'd1, "R5 no capture on rise");
    pulse();
    chk({7'd0, tx_bit_o}, 8'd0, "R5 capture on fall");
    txdl_i = 1'b1;
    idle(4);
    chk({7'd0, tx_bit_o}, 8'd0, "R5 hold between pulses");
    pulse();
    chk({7'd0, tx_bit_o}, 8'd0, "R5 hold across rise");
    pulse();
    chk({7'd0, tx_bit_o}, 8'd1, "R5 second capture");
  endtask

  task automatic t_rx_map();
    for (int k = 0; k < 5; k++) begin
      logic [7:0] one;
      one = 8'(1 << (4 - k));
      sel_i = 5'(1 << k);
      send(one);
      to_fall();
      chk({7'd0, rxdl_o}, 8'd1, "R6 bit set");
      send(~one);
      to_fall();
      chk({7'd0, rxdl_o}, 8'd0, "R6 bit clear");
    end
  endtask

  task automatic t_rx_align();
    sel_i = 5'b00100;
    if (exp_clk) pulse();
    send(8'h04);
    chk({7'd0, rxdl_o}, 8'd0, "R7 no early update");
    pulse();
    chk({7'd0, rxdl_o}, 8'd0, "R7 no update on rise");
    pulse();
    chk({7'd0, rxdl_o}, 8'd1, "R7 update on fall");
  endtask

  task automatic t_slip();
    sel_i = 5'b01000;
    send(8'h02);
    chk({7'd0, dlclk_o}, {7'd0, exp_clk}, "R8 phase after strobe");
    send(8'h00);
    chk({7'd0, dlclk_o}, {7'd0, exp_clk}, "R8 phase after double strobe");
    to_fall();
    chk({7'd0, rxdl_o}, 8'd0, "R8 earlier bit lost");
    pulse();
    pulse();
    chk({7'd0, rxdl_o}, 8'd0, "R8 bit repeated");
    send(8'h02);
    to_fall();
    chk({7'd0, rxdl_o}, 8'd1, "R8 resume after slip");
  endtask

  initial begin
    t_reset();
    t_clock();
    t_select();
    t_invalid();
    t_tx();
    t_rx_map();
    t_rx_align();
    t_slip();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule